// File: doc/BRIEF.md
# MSI Termination Register Unit

This unit sits at the end of the inbound write path of a PCIe root complex. Each memory write that carries a message-signalled interrupt arrives on a simple write port. The address picks a group and an index register inside that group. The data value picks one pending bit inside that register. The unit holds 16 groups of 8 index registers, each 21 bits wide, for 2688 vectors in all. It drives one level interrupt line per group toward the interrupt controller.

Software services a group line in two steps. It first reads the group's summary register to find which index registers are non-zero. It then reads each of those index registers. A read of an index register returns its pending bits and clears them in the same cycle. A write that lands in that same cycle is kept pending and is not lost.

A write whose address falls outside the decoded index window, or whose data value is not a valid bit position, changes no state. It sets a sticky error flag, which only reset clears.

Top module: `msi_term_unit`

## Requirements
- R1: After reset every irq_out line is 0, err_sticky is 0, and every index register reads back as 0.
- R2: A write is decoded as an index write when addr bit 23 is 0 and addr bits [15:0] are all 0. The group is addr[22:19] and the index is addr[18:16]. Data value d in 0..20 sets bit d of that index register, and a later read of it returns 1<<d in rd_data[20:0].
- R3: irq_out[g] is 1 exactly when some index register of group g holds a pending bit. It rises in the cycle after the clock edge that accepts the write.
- R4: A read at 0x800000 + (g<<16) returns the summary of group g. Bit n is 1 when index register n of group g is non-zero, and bits [31:8] are 0. Such a read clears nothing.
- R5: rd_data holds the result of a read in the cycle after rd_en is sampled. A read of an index register returns its bits and clears that register, so a second read returns 0.
- R6: When a write sets a bit in the index register being read in the same cycle, the read returns the old contents only, and the new bit stays pending.
- R7: A write with a data value of 21 or more changes no pending bit and sets err_sticky.
- R8: A write outside the index window changes no pending bit and sets err_sticky. This covers any nonzero bit in addr[15:0], and it covers addr bit 23 set, which includes the summary range.
- R9: err_sticky stays 1 until reset.
- R10: Vector v lands in group v%16, index (v/16)/21 and bit (v/16)%21, so consecutive vectors land in consecutive groups.
- R11: Writes to one index register accumulate by OR. Writing an already-pending bit again leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 24 | Write byte offset within the unit's window |
| wr_data | input | 32 | Write data, the bit position to set |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 24 | Read byte offset |
| rd_data | output | 32 | Read result, valid the cycle after rd_en |
| irq_out | output | 16 | Level interrupt, one per group |
| err_sticky | output | 1 | Set by any rejected write |

## Verification
A wrong decode or a lost bit is visible at the ports one cycle after the write edge, because the interrupt line of the expected group either stays low or a different line rises. A wrong clear or a lost same-cycle write shows up on the next read, as a nonzero second read or a missing bit. Summary corruption shows up as a disagreement between the summary word and the index register that is read right after it. Rejected writes are checked through both the flag and unchanged interrupt lines in the following cycle.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;

  localparam int unsigned DEF_GROUPS  = 16;
  localparam int unsigned DEF_INDEXES = 8;
  localparam int unsigned DEF_BITS    = 21;
  localparam int unsigned DEF_ADDR_W  = 24;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_FLD_LSB = 16;

  // Logical vector number of a pending bit: groups rotate fastest.
  function automatic int unsigned vector_of(input int unsigned grp,
                                            input int unsigned idx,
                                            input int unsigned bitpos,
                                            input int unsigned ngroups,
                                            input int unsigned nbits);
    return ((idx * nbits) + bitpos) * ngroups + grp;
  endfunction

endpackage

// File: rtl/msi_wr_decode.sv
module msi_wr_decode #(
  parameter int unsigned NGRP    = 16,
  parameter int unsigned NIDX    = 8,
  parameter int unsigned NBITS   = 21,
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FLD_LSB = 16
) (
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic                      ok,
  output logic                      bad,
  output logic [$clog2(NGRP)-1:0]   grp,
  output logic [$clog2(NIDX)-1:0]   idx,
  output logic [NBITS-1:0]          mask
);
  localparam int unsigned GW      = $clog2(NGRP);
  localparam int unsigned IW      = $clog2(NIDX);
  localparam int unsigned SUM_BIT = FLD_LSB + IW + GW;

  logic addr_fits;
  logic data_fits;

  always_comb begin
    addr_fits = (wr_addr[SUM_BIT] == 1'b0) && (wr_addr[FLD_LSB-1:0] == '0);
    data_fits = (wr_data < DATA_W'(NBITS));
    ok        = wr_en && addr_fits && data_fits;
    bad       = wr_en && !(addr_fits && data_fits);
    grp       = wr_addr[FLD_LSB+IW +: GW];
    idx       = wr_addr[FLD_LSB +: IW];
    mask      = data_fits ? ({{(NBITS-1){1'b0}}, 1'b1} << wr_data) : '0;
  end
endmodule

// File: rtl/msi_group_bank.sv
module msi_group_bank #(
  parameter int unsigned NIDX  = 8,
  parameter int unsigned NBITS = 21
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          set_en,
  input  logic [$clog2(NIDX)-1:0]       set_idx,
  input  logic [NBITS-1:0]              set_mask,
  input  logic                          clr_en,
  input  logic [$clog2(NIDX)-1:0]       clr_idx,
  output logic [NIDX-1:0][NBITS-1:0]    pend,
  output logic [NIDX-1:0]               summary,
  output logic                          irq
);
  for (genvar i = 0; i < NIDX; i++) begin : g_idx
    logic set_hit;
    logic clr_hit;
    assign set_hit = set_en && (set_idx == i);
    assign clr_hit = clr_en && (clr_idx == i);

    // Clear from a read and set from a write in one cycle: the set survives.
    always_ff @(posedge clk) begin
      if (!rst_n) pend[i] <= '0;
      else        pend[i] <= (clr_hit ? '0 : pend[i]) | (set_hit ? set_mask : '0);
    end

    assign summary[i] = |pend[i];
  end

  assign irq = |summary;
endmodule

// File: rtl/msi_rd_port.sv
module msi_rd_port #(
  parameter int unsigned NGRP    = 16,
  parameter int unsigned NIDX    = 8,
  parameter int unsigned NBITS   = 21,
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FLD_LSB = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                rd_en,
  input  logic [ADDR_W-1:0]                   rd_addr,
  input  logic [NGRP-1:0][NIDX-1:0][NBITS-1:0] pend_all,
  input  logic [NGRP-1:0][NIDX-1:0]           summ_all,
  output logic [DATA_W-1:0]                   rd_data,
  output logic                                clr_en,
  output logic [$clog2(NGRP)-1:0]             clr_grp,
  output logic [$clog2(NIDX)-1:0]             clr_idx,
  output logic                                sum_hit
);
  localparam int unsigned GW      = $clog2(NGRP);
  localparam int unsigned IW      = $clog2(NIDX);
  localparam int unsigned SUM_BIT = FLD_LSB + IW + GW;

  logic            low_zero;
  logic [GW-1:0]   sum_grp;

  always_comb begin
    low_zero = (rd_addr[FLD_LSB-1:0] == '0);
    clr_en   = rd_en && !rd_addr[SUM_BIT] && low_zero;
    sum_hit  = rd_en && rd_addr[SUM_BIT] && low_zero &&
               ((rd_addr[SUM_BIT-1:FLD_LSB] >> GW) == '0);
    clr_grp  = rd_addr[FLD_LSB+IW +: GW];
    clr_idx  = rd_addr[FLD_LSB +: IW];
    sum_grp  = rd_addr[FLD_LSB +: GW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_data <= '0;
    else if (clr_en)  rd_data <= DATA_W'(pend_all[clr_grp][clr_idx]);
    else if (sum_hit) rd_data <= DATA_W'(summ_all[sum_grp]);
    else if (rd_en)   rd_data <= '0;
  end
endmodule

// File: rtl/msi_term_unit.sv
module msi_term_unit
  import msi_term_pkg::*;
#(
  parameter int unsigned NGRP    = DEF_GROUPS,
  parameter int unsigned NIDX    = DEF_INDEXES,
  parameter int unsigned NBITS   = DEF_BITS,
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned FLD_LSB = DEF_FLD_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NGRP-1:0]   irq_out,
  output logic              err_sticky
);
  localparam int unsigned GW = $clog2(NGRP);
  localparam int unsigned IW = $clog2(NIDX);

  // Named internal events, observed by the bound checker.
  logic                wr_ok;
  logic                wr_bad;
  logic [GW-1:0]       wr_grp;
  logic [IW-1:0]       wr_idx;
  logic [NBITS-1:0]    wr_mask;
  int unsigned         wr_vec;
  logic                rd_clr;
  logic [GW-1:0]       rd_grp;
  logic [IW-1:0]       rd_idx;
  logic                rd_sum_hit;

  logic [NGRP-1:0][NIDX-1:0][NBITS-1:0] pend_all;
  logic [NGRP-1:0][NIDX-1:0]            summ_all;

  msi_wr_decode #(
    .NGRP(NGRP), .NIDX(NIDX), .NBITS(NBITS),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLD_LSB(FLD_LSB)
  ) u_dec (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .ok     (wr_ok),
    .bad    (wr_bad),
    .grp    (wr_grp),
    .idx    (wr_idx),
    .mask   (wr_mask)
  );

  always_comb begin
    wr_vec = vector_of(32'(wr_grp), 32'(wr_idx), 32'(wr_data[7:0]), NGRP, NBITS);
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    msi_group_bank #(.NIDX(NIDX), .NBITS(NBITS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (wr_ok && (wr_grp == g)),
      .set_idx (wr_idx),
      .set_mask(wr_mask),
      .clr_en  (rd_clr && (rd_grp == g)),
      .clr_idx (rd_idx),
      .pend    (pend_all[g]),
      .summary (summ_all[g]),
      .irq     (irq_out[g])
    );
  end

  msi_rd_port #(
    .NGRP(NGRP), .NIDX(NIDX), .NBITS(NBITS),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLD_LSB(FLD_LSB)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .pend_all(pend_all),
    .summ_all(summ_all),
    .rd_data (rd_data),
    .clr_en  (rd_clr),
    .clr_grp (rd_grp),
    .clr_idx (rd_idx),
    .sum_hit (rd_sum_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      err_sticky <= 1'b0;
    else if (wr_bad) err_sticky <= 1'b1;
  end
endmodule

// File: rtl/msi_term_checks.sv
module msi_term_checks #(
  parameter int unsigned NGRP  = 16,
  parameter int unsigned NIDX  = 8,
  parameter int unsigned NBITS = 21
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic                    wr_ok,
  input logic                    wr_bad,
  input logic [$clog2(NGRP)-1:0] wr_grp,
  input int unsigned             wr_vec,
  input logic                    rd_en,
  input logic                    rd_sum_hit,
  input logic [NGRP-1:0]         irq_out,
  input logic                    err_sticky
);
  localparam int unsigned TOTAL = NGRP * NIDX * NBITS;

  logic [$clog2(NGRP)-1:0] q_grp;
  always_ff @(posedge clk) q_grp <= wr_grp;

  // R3: an accepted write raises its group line on the next cycle
  p_write_raises_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> irq_out[q_grp]);

  // R7: a rejected write raises the error flag
  p_bad_sets_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> err_sticky);

  // R9: the error flag never falls outside reset
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  // R8: a rejected write with no read in flight leaves every line unchanged
  p_bad_no_effect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bad && !rd_en) |=> $stable(irq_out));

  // R4: a summary read clears nothing
  p_sum_read_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sum_hit && !wr_en) |=> $stable(irq_out));

  // R10: every accepted write maps to a vector inside the terminated range
  p_vec_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> (wr_vec < TOTAL));
endmodule

bind msi_term_unit msi_term_checks #(.NGRP(NGRP), .NIDX(NIDX), .NBITS(NBITS)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_ok     (wr_ok),
  .wr_bad    (wr_bad),
  .wr_grp    (wr_grp),
  .wr_vec    (wr_vec),
  .rd_en     (rd_en),
  .rd_sum_hit(rd_sum_hit),
  .irq_out   (irq_out),
  .err_sticky(err_sticky)
);

// File: tb/test_msi_term_unit.sv
module test_msi_term_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [23:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [23:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] irq_out;
  logic        err_sticky;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  msi_term_unit i_msi_term_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_out(irq_out), .err_sticky(err_sticky)
  );

  // Vectors: each entry is a logical vector number, expectations derived in the loop.
  localparam int unsigned VECS [8] = '{0, 1, 15, 16, 335, 336, 1000, 2687};

  function automatic logic [23:0] a_idx(input int g, input int i);
    return 24'((g * 524288) + (i * 65536));
  endfunction
  function automatic logic [23:0] a_sum(input int g);
    return 24'(8388608 + g * 65536);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic do_wr(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [23:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();

    // R1: reset state
    check("R1 irq", 32'(irq_out), 0);
    check("R1 err", 32'(err_sticky), 0);
    do_rd(a_idx(9, 4), d);
    check("R1 idx read", d, 0);

    // Table walk: R2 R3 R4 R5 R10
    foreach (VECS[k]) begin
      int unsigned v, g, q, i, b;
      v = VECS[k]; g = v % 16; q = v / 16; i = q / 21; b = q % 21;
      do_wr(a_idx(g, i), b);
      check("R3/R10 irq line", 32'(irq_out), 32'(1) << g);
      do_rd(a_sum(g), d);
      check("R4 summary", d, 32'(1) << i);
      do_rd(a_idx(g, i), d);
      check("R2/R5 index read", d, 32'(1) << b);
      check("R5 irq after clear", 32'(irq_out), 0);
      do_rd(a_idx(g, i), d);
      check("R5 second read", d, 0);
    end

    // R11: accumulate and idempotent write
    do_wr(a_idx(5, 7), 0);
    do_wr(a_idx(5, 7), 20);
    do_wr(a_idx(5, 7), 20);
    do_rd(a_idx(5, 7), d);
    check("R11 accumulate", d, 32'h0010_0001);

    // R4: two index registers of one group, other group empty
    do_wr(a_idx(3, 1), 2);
    do_wr(a_idx(3, 6), 9);
    do_rd(a_sum(3), d);
    check("R4 two indexes", d, 32'h42);
    do_rd(a_sum(4), d);
    check("R4 empty group", d, 0);
    check("R4 summary read keeps irq", 32'(irq_out), 32'h8);
    do_rd(a_idx(3, 1), d);
    do_rd(a_idx(3, 6), d);

    // R6: write lands in the cycle of the clearing read
    do_wr(a_idx(2, 1), 3);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a_idx(2, 1);
    wr_en = 1'b1; wr_addr = a_idx(2, 1); wr_data = 5;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check("R6 old contents", rd_data, 32'h8);
    check("R6 irq kept", 32'(irq_out), 32'h4);
    do_rd(a_idx(2, 1), d);
    check("R6 new bit pending", d, 32'h20);

    // R7: out-of-range data
    check("R7 err before", 32'(err_sticky), 0);
    do_wr(a_idx(1, 0), 21);
    check("R7 err set", 32'(err_sticky), 1);
    check("R7 no irq", 32'(irq_out), 0);
    do_rd(a_idx(1, 0), d);
    check("R7 nothing set", d, 0);
    // R9: stays set
    repeat (5) @(negedge clk);
    check("R9 sticky", 32'(err_sticky), 1);

    // R1: reset clears pending and flag
    do_wr(a_idx(7, 2), 4);
    do_reset();
    check("R1 irq after reset", 32'(irq_out), 0);
    check("R9 cleared by reset", 32'(err_sticky), 0);

    // R8: bad low bits
    do_wr(a_idx(6, 3) | 24'h8, 1);
    check("R8 low bits err", 32'(err_sticky), 1);
    check("R8 low bits irq", 32'(irq_out), 0);
    do_rd(a_idx(6, 3), d);
    check("R8 low bits nothing set", d, 0);
    do_reset();
    // R8: write into summary range
    do_wr(a_sum(6), 1);
    check("R8 summary write err", 32'(err_sticky), 1);
    check("R8 summary write irq", 32'(irq_out), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule